// File: doc/BRIEF.md
# Four-Way Instruction Address Translation Buffer

This block is a small, fully associative translation buffer for instruction fetch. It holds four page entries, each with a virtual page number, an address-space identifier, a physical page number, a page-size code, a shared flag, a protection field and a valid bit. A lookup request presents a virtual address, the current address-space identifier and a flag that says whether that identifier takes part in matching. One cycle later the block reports a single hit (with entry index, physical address and protection), a multiple hit, or a miss.

Refills come from a larger unified buffer outside this block. A fill request carries one complete entry and writes it into the way named by a 6-bit replacement field. Every use of a way, whether a single-hit lookup or a fill, rewrites that field with a fixed AND/OR mask per way. The same field is decoded in a fixed priority order to pick the next victim. The field can also be loaded directly, as software would when it writes the control register that holds it. A fill that finds no victim pattern in the field reports an error and clears the field.

A small controller sequences the work. Its states are ST_IDLE (nothing reported), ST_RESP (lookup result valid), ST_FILLED (fill written) and ST_FERR (fill refused). On every edge it moves to one state picked by that cycle's request. A field load goes to ST_IDLE. An accepted fill goes to ST_FILLED and a refused fill goes to ST_FERR. A lookup goes to ST_RESP, and no request goes to ST_IDLE. The load beats a fill, and a fill beats a lookup.

Top module: `ifetch_xlat`

## Requirements
- R1: After reset all entries are invalid, `lru_state` is 0 and `rsp_valid`, `fill_done` and `fill_err` are low; a lookup then misses.
- R2: An entry matches when it is valid, its page holds the address, and it is shared, or `lk_use_asid` is 0, or its identifier equals `lk_asid`.
- R3: Page-size code 0, 1, 2, 3 gives 1 KiB, 4 KiB, 64 KiB, 1 MiB. The page starts at the entry number shifted left by 10 with its offset bits cleared. On a hit, the physical address takes the physical page number (shifted left by 10) for the bits above the offset, and the virtual address for the offset bits.
- R4: With two or more matches `rsp_multi` is 1 and `rsp_hit` is 0. With none, both are 0. In both cases `lru_state` is unchanged.
- R5: Field bit i stands for bit i+2 of an 8-bit byte B, whose two low bits are zero. A single hit on way 0 does B&=0x1F. Way 1 does B=(B&0xE7)|0x80, way 2 does B=(B&0xFB)|0x50 and way 3 does B|=0x2C. The change is visible with the response.
- R6: The victim is the first rule that holds: B&0xE0==0xE0 gives way 0; B&0x98==0x18 gives way 1; B&0x54==0x04 gives way 2; B&0x2C==0 gives way 3.
- R7: An accepted fill writes all fields of the victim way. One cycle later `fill_done` pulses and `fill_idx` names the way. It also updates `lru_state` as a use of that way would.
- R8: A fill while no victim rule holds writes no entry. It pulses `fill_err` and sets `lru_state` to 0.
- R9: `lru_wr_en` loads `lru_wr_data` into `lru_state` on the next edge. A fill or lookup in the same cycle is dropped.
- R10: A lookup in the same cycle as a fill is dropped: `rsp_valid` stays low and no entry or field change comes from it.
- R11: A response comes exactly one cycle after the request. At most one of `rsp_valid`, `fill_done` and `fill_err` is high in any cycle. Response fields hold their values until the next response.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lk_valid | input | 1 | Lookup request |
| lk_vaddr | input | VA_W | Virtual address to translate |
| lk_asid | input | ASID_W | Current address-space identifier |
| lk_use_asid | input | 1 | Identifier takes part in matching |
| fill_en | input | 1 | Fill request |
| fill_valid | input | 1 | Valid bit of the new entry |
| fill_vpn | input | VA_W-10 | Virtual page number of the new entry |
| fill_asid | input | ASID_W | Identifier of the new entry |
| fill_ppn | input | PA_W-10 | Physical page number of the new entry |
| fill_size | input | 2 | Page-size code of the new entry |
| fill_shared | input | 1 | Shared flag of the new entry |
| fill_prot | input | 2 | Protection bits of the new entry |
| lru_wr_en | input | 1 | Load replacement field |
| lru_wr_data | input | 6 | Value to load |
| rsp_valid | output | 1 | Lookup result valid |
| rsp_hit | output | 1 | Exactly one entry matched |
| rsp_multi | output | 1 | More than one entry matched |
| rsp_idx | output | 2 | Matched way |
| rsp_paddr | output | PA_W | Translated physical address |
| rsp_prot | output | 2 | Protection bits of the matched way |
| fill_done | output | 1 | Fill written |
| fill_err | output | 1 | Fill refused, field cleared |
| fill_idx | output | 2 | Way written by the fill |
| lru_state | output | 6 | Replacement field |

## Verification
The bench uses the default widths: a 32-bit virtual address, a 29-bit physical address and an 8-bit identifier. These widths make room for 1 MiB pages at high virtual addresses and for physical page bits that differ from the virtual ones inside a page. With the 8-bit identifier, random lookups can both equal and differ from an entry's identifier. Random fills draw their page bases from a small pool, so pages overlap often. This brings the multiple-hit path and each way's mask update within reach as well as plain hits and misses. Directed steps then cover the full four-fill replacement cycle and the refused fill after loading field value 0x02. They also cover the load-over-fill and fill-over-lookup priorities.

// File: rtl/ifx_pkg.sv
package ifx_pkg;
    localparam int unsigned NUM_WAYS = 4;
    localparam int unsigned WAY_W    = $clog2(NUM_WAYS);
    localparam int unsigned LRU_W    = 6;
    localparam int unsigned PG_SHIFT = 10;

    typedef enum logic [1:0] {
        PG_1K  = 2'd0,
        PG_4K  = 2'd1,
        PG_64K = 2'd2,
        PG_1M  = 2'd3
    } pg_size_e;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_RESP   = 2'd1,
        ST_FILLED = 2'd2,
        ST_FERR   = 2'd3
    } ctl_state_e;

    // page-number bits that belong to the in-page offset for each size
    function automatic logic [9:0] size_mask(input pg_size_e sz);
        logic [9:0] m;
        unique case (sz)
            PG_1K:  m = 10'h000;
            PG_4K:  m = 10'h003;
            PG_64K: m = 10'h03F;
            PG_1M:  m = 10'h3FF;
        endcase
        return m;
    endfunction

    // field update for a use of one way (field bit i = byte bit i+2)
    function automatic logic [LRU_W-1:0] lru_touch(input logic [LRU_W-1:0] cur,
                                                   input logic [WAY_W-1:0] way);
        logic [LRU_W-1:0] nxt;
        unique case (way)
            2'd0: nxt = cur & 6'h07;
            2'd1: nxt = (cur & 6'h39) | 6'h20;
            2'd2: nxt = (cur & 6'h3E) | 6'h14;
            2'd3: nxt = cur | 6'h0B;
        endcase
        return nxt;
    endfunction
endpackage

// File: rtl/xlat_way_cmp.sv
module xlat_way_cmp
    import ifx_pkg::*;
#(
    parameter int VA_W   = 32,
    parameter int PA_W   = 29,
    parameter int ASID_W = 8
) (
    input  logic                   e_valid,
    input  logic                   e_shared,
    input  logic [VA_W-11:0]       e_vpn,
    input  logic [ASID_W-1:0]      e_asid,
    input  logic [PA_W-11:0]       e_ppn,
    input  pg_size_e               e_size,
    input  logic [VA_W-1:0]        va,
    input  logic [ASID_W-1:0]      asid,
    input  logic                   use_asid,
    output logic                   match,
    output logic [PA_W-1:0]        paddr
);
    localparam int VPN_W = VA_W - PG_SHIFT;
    localparam int PPN_W = PA_W - PG_SHIFT;

    logic [VPN_W-1:0] off_mask;
    logic [PPN_W-1:0] poff_mask;
    logic             range_ok;
    logic             asid_ok;

    always_comb begin
        off_mask  = {{(VPN_W-10){1'b0}}, size_mask(e_size)};
        poff_mask = {{(PPN_W-10){1'b0}}, size_mask(e_size)};
        range_ok  = (((va[VA_W-1:PG_SHIFT] ^ e_vpn) & ~off_mask) == '0);
        asid_ok   = e_shared || !use_asid || (e_asid == asid);
        match     = e_valid && range_ok && asid_ok;
        paddr     = {(e_ppn & ~poff_mask) | (va[PPN_W+PG_SHIFT-1:PG_SHIFT] & poff_mask),
                     va[PG_SHIFT-1:0]};
    end
endmodule

// File: rtl/xlat_lru_ctl.sv
module xlat_lru_ctl
    import ifx_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ld_en,
    input  logic [LRU_W-1:0] ld_data,
    input  logic             clear_en,
    input  logic             touch_en,
    input  logic [WAY_W-1:0] touch_way,
    output logic [LRU_W-1:0] lru,
    output logic [WAY_W-1:0] victim,
    output logic             victim_ok
);
    always_ff @(posedge clk) begin
        if (!rst_n)         lru <= '0;
        else if (ld_en)     lru <= ld_data;
        else if (clear_en)  lru <= '0;
        else if (touch_en)  lru <= lru_touch(lru, touch_way);
    end

    // priority decode, way 0 first
    always_comb begin
        victim    = '0;
        victim_ok = 1'b1;
        if ((lru & 6'h38) == 6'h38)      victim = 2'd0;
        else if ((lru & 6'h26) == 6'h06) victim = 2'd1;
        else if ((lru & 6'h15) == 6'h01) victim = 2'd2;
        else if ((lru & 6'h0B) == 6'h00) victim = 2'd3;
        else                             victim_ok = 1'b0;
    end
endmodule

// File: rtl/ifetch_xlat.sv
module ifetch_xlat
    import ifx_pkg::*;
#(
    parameter int VA_W   = 32,
    parameter int PA_W   = 29,
    parameter int ASID_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              lk_valid,
    input  logic [VA_W-1:0]   lk_vaddr,
    input  logic [ASID_W-1:0] lk_asid,
    input  logic              lk_use_asid,
    input  logic              fill_en,
    input  logic              fill_valid,
    input  logic [VA_W-11:0]  fill_vpn,
    input  logic [ASID_W-1:0] fill_asid,
    input  logic [PA_W-11:0]  fill_ppn,
    input  logic [1:0]        fill_size,
    input  logic              fill_shared,
    input  logic [1:0]        fill_prot,
    input  logic              lru_wr_en,
    input  logic [5:0]        lru_wr_data,
    output logic              rsp_valid,
    output logic              rsp_hit,
    output logic              rsp_multi,
    output logic [1:0]        rsp_idx,
    output logic [PA_W-1:0]   rsp_paddr,
    output logic [1:0]        rsp_prot,
    output logic              fill_done,
    output logic              fill_err,
    output logic [1:0]        fill_idx,
    output logic [5:0]        lru_state
);
    localparam int VPN_W = VA_W - PG_SHIFT;
    localparam int PPN_W = PA_W - PG_SHIFT;

    // entry storage
    logic [NUM_WAYS-1:0] ent_v;
    logic [NUM_WAYS-1:0] ent_sh;
    logic [VPN_W-1:0]    ent_vpn  [NUM_WAYS];
    logic [ASID_W-1:0]   ent_asid [NUM_WAYS];
    logic [PPN_W-1:0]    ent_ppn  [NUM_WAYS];
    pg_size_e            ent_size [NUM_WAYS];
    logic [1:0]          ent_prot [NUM_WAYS];

    logic [NUM_WAYS-1:0] way_hit;
    logic [PA_W-1:0]     way_pa [NUM_WAYS];
    logic [WAY_W-1:0]    hit_idx;
    logic [2:0]          hit_cnt;
    logic                single_hit;

    logic [WAY_W-1:0]    victim_idx;
    logic                victim_ok;
    logic                do_ld, do_fill, do_look, fill_ok;
    ctl_state_e          state_q, state_d;

    generate
        for (genvar w = 0; w < NUM_WAYS; w++) begin : g_way
            xlat_way_cmp #(.VA_W(VA_W), .PA_W(PA_W), .ASID_W(ASID_W)) u_cmp (
                .e_valid  (ent_v[w]),
                .e_shared (ent_sh[w]),
                .e_vpn    (ent_vpn[w]),
                .e_asid   (ent_asid[w]),
                .e_ppn    (ent_ppn[w]),
                .e_size   (ent_size[w]),
                .va       (lk_vaddr),
                .asid     (lk_asid),
                .use_asid (lk_use_asid),
                .match    (way_hit[w]),
                .paddr    (way_pa[w])
            );
        end
    endgenerate

    always_comb begin
        hit_idx = '0;
        hit_cnt = '0;
        for (int w = 0; w < NUM_WAYS; w++) begin
            if (way_hit[w]) begin
                hit_idx = WAY_W'(w);
                hit_cnt = hit_cnt + 3'd1;
            end
        end
        single_hit = (hit_cnt == 3'd1);
    end

    // request arbitration: load > fill > lookup
    always_comb begin
        do_ld   = lru_wr_en;
        do_fill = fill_en && !lru_wr_en;
        do_look = lk_valid && !fill_en && !lru_wr_en;
        fill_ok = do_fill && victim_ok;
    end

    xlat_lru_ctl u_lru (
        .clk       (clk),
        .rst_n     (rst_n),
        .ld_en     (do_ld),
        .ld_data   (lru_wr_data),
        .clear_en  (do_fill && !victim_ok),
        .touch_en  (fill_ok || (do_look && single_hit)),
        .touch_way (fill_ok ? victim_idx : hit_idx),
        .lru       (lru_state),
        .victim    (victim_idx),
        .victim_ok (victim_ok)
    );

    // next-state selection
    always_comb begin
        if (do_ld)        state_d = ST_IDLE;
        else if (do_fill) state_d = victim_ok ? ST_FILLED : ST_FERR;
        else if (do_look) state_d = ST_RESP;
        else              state_d = ST_IDLE;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // outputs decoded from state
    always_comb begin
        rsp_valid = 1'b0;
        fill_done = 1'b0;
        fill_err  = 1'b0;
        unique case (state_q)
            ST_IDLE:   ;
            ST_RESP:   rsp_valid = 1'b1;
            ST_FILLED: fill_done = 1'b1;
            ST_FERR:   fill_err  = 1'b1;
        endcase
    end

    // response and fill-index registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_hit   <= 1'b0;
            rsp_multi <= 1'b0;
            rsp_idx   <= '0;
            rsp_paddr <= '0;
            rsp_prot  <= '0;
            fill_idx  <= '0;
        end else begin
            if (do_look) begin
                rsp_hit   <= single_hit;
                rsp_multi <= (hit_cnt > 3'd1);
                rsp_idx   <= single_hit ? hit_idx : '0;
                rsp_paddr <= single_hit ? way_pa[hit_idx] : '0;
                rsp_prot  <= single_hit ? ent_prot[hit_idx] : '0;
            end
            if (fill_ok) fill_idx <= victim_idx;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n)       ent_v <= '0;
        else if (fill_ok) ent_v[victim_idx] <= fill_valid;
    end

    always_ff @(posedge clk) begin
        if (fill_ok) begin
            ent_sh[victim_idx]   <= fill_shared;
            ent_vpn[victim_idx]  <= fill_vpn;
            ent_asid[victim_idx] <= fill_asid;
            ent_ppn[victim_idx]  <= fill_ppn;
            ent_size[victim_idx] <= pg_size_e'(fill_size);
            ent_prot[victim_idx] <= fill_prot;
        end
    end
endmodule

// File: rtl/xlat_chk.sv
module xlat_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       fill_en,
    input logic       lru_wr_en,
    input logic [5:0] lru_wr_data,
    input logic       rsp_valid,
    input logic       rsp_hit,
    input logic       rsp_multi,
    input logic [1:0] rsp_idx,
    input logic       fill_done,
    input logic       fill_err,
    input logic [1:0] fill_idx,
    input logic [5:0] lru_state,
    input logic [1:0] victim_idx
);
    // R4
    hit_multi_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> !(rsp_hit && rsp_multi));

    // R11
    one_event_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({rsp_valid, fill_done, fill_err}));

    // R8
    err_clears_field_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fill_err |-> (lru_state == 6'h00));

    // R9
    field_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        lru_wr_en |=> (lru_state == $past(lru_wr_data)) && !fill_done && !fill_err && !rsp_valid);

    // R5
    hit_not_victim_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_hit) |-> (victim_idx != rsp_idx));

    // R7
    fill_not_victim_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fill_done |-> (victim_idx != fill_idx));

    // R7
    fill_origin_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fill_done |-> $past(fill_en) && !$past(lru_wr_en));

    // R10
    fill_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fill_en && !lru_wr_en) |=> !rsp_valid);
endmodule

bind ifetch_xlat xlat_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .fill_en     (fill_en),
    .lru_wr_en   (lru_wr_en),
    .lru_wr_data (lru_wr_data),
    .rsp_valid   (rsp_valid),
    .rsp_hit     (rsp_hit),
    .rsp_multi   (rsp_multi),
    .rsp_idx     (rsp_idx),
    .fill_done   (fill_done),
    .fill_err    (fill_err),
    .fill_idx    (fill_idx),
    .lru_state   (lru_state),
    .victim_idx  (victim_idx)
);

// File: tb/sim_ifetch_xlat.sv
module sim_ifetch_xlat;
    localparam int VA_W = 32, PA_W = 29, ASID_W = 8;

    logic clk = 1'b0, rst_n = 1'b0;
    logic lk_valid = 0, lk_use_asid = 0, fill_en = 0, fill_valid = 0, fill_shared = 0, lru_wr_en = 0;
    logic [31:0] lk_vaddr = '0;
    logic [7:0]  lk_asid = '0, fill_asid = '0;
    logic [21:0] fill_vpn = '0;
    logic [18:0] fill_ppn = '0;
    logic [1:0]  fill_size = '0, fill_prot = '0;
    logic [5:0]  lru_wr_data = '0;
    logic        rsp_valid, rsp_hit, rsp_multi, fill_done, fill_err;
    logic [1:0]  rsp_idx, rsp_prot, fill_idx;
    logic [28:0] rsp_paddr;
    logic [5:0]  lru_state;

    int checks = 0, errors = 0, cyc = 0;

    always #4 clk = ~clk;

    ifetch_xlat #(.VA_W(VA_W), .PA_W(PA_W), .ASID_W(ASID_W)) u0 (.*);

    // bench model
    bit          mv [4];
    bit          msh[4];
    logic [21:0] mvpn[4];
    logic [7:0]  masid[4];
    logic [18:0] mppn[4];
    logic [1:0]  msz[4], mpr[4];
    logic [7:0]  mbyte;

    function automatic logic [31:0] pg_bytes(input logic [1:0] s);
        case (s)
            2'd0: return 32'd1024;
            2'd1: return 32'd4096;
            2'd2: return 32'd65536;
            default: return 32'd1048576;
        endcase
    endfunction

    function automatic logic [7:0] byte_touch(input logic [7:0] b, input int w);
        case (w)
            0: return b & 8'h1F;
            1: return (b & 8'hE7) | 8'h80;
            2: return (b & 8'hFB) | 8'h50;
            default: return b | 8'h2C;
        endcase
    endfunction

    function automatic int pick_victim(input logic [7:0] b);
        if ((b & 8'hE0) == 8'hE0) return 0;
        if ((b & 8'h98) == 8'h18) return 1;
        if ((b & 8'h54) == 8'h04) return 2;
        if ((b & 8'h2C) == 8'h00) return 3;
        return -1;
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp, input string what);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
        lk_valid = 0; fill_en = 0; lru_wr_en = 0;
    endtask

    task automatic lookup(input string req, input logic [31:0] va, input logic [7:0] asid, input bit use_id);
        int n = 0, idx = 0;
        logic [31:0] start, sz, pa;
        for (int w = 0; w < 4; w++) begin
            sz = pg_bytes(msz[w]);
            start = {mvpn[w], 10'b0} & ~(sz - 1);
            if (mv[w] && (msh[w] || !use_id || masid[w] == asid) &&
                va >= start && va <= start + sz - 1) begin
                n++; idx = w;
            end
        end
        lk_vaddr = va; lk_asid = asid; lk_use_asid = use_id; lk_valid = 1;
        step();
        chk(req, rsp_valid, 1, "rsp_valid");
        chk(req, rsp_hit, (n == 1), "rsp_hit");
        chk(req, rsp_multi, (n > 1), "rsp_multi");
        if (n == 1) begin
            sz = pg_bytes(msz[idx]);
            pa = ({3'b0, mppn[idx], 10'b0} & ~(sz - 1)) | (va & (sz - 1));
            chk(req, rsp_idx, idx, "rsp_idx");
            chk(req, rsp_paddr, pa & 32'h1FFF_FFFF, "rsp_paddr");
            chk(req, rsp_prot, mpr[idx], "rsp_prot");
            mbyte = byte_touch(mbyte, idx);
        end
        chk(req, lru_state, mbyte[7:2], "lru_state");
    endtask

    task automatic fill(input string req, input logic [31:0] base, input logic [7:0] asid,
                        input logic [18:0] ppn, input logic [1:0] sz, input bit sh,
                        input logic [1:0] pr, input bit v);
        int vic = pick_victim(mbyte);
        fill_vpn = base[31:10]; fill_asid = asid; fill_ppn = ppn; fill_size = sz;
        fill_shared = sh; fill_prot = pr; fill_valid = v; fill_en = 1;
        step();
        if (vic < 0) begin
            chk(req, fill_err, 1, "fill_err");
            chk(req, fill_done, 0, "fill_done");
            mbyte = 8'h00;
        end else begin
            chk(req, fill_done, 1, "fill_done");
            chk(req, fill_idx, vic, "fill_idx");
            mv[vic] = v; msh[vic] = sh; mvpn[vic] = base[31:10]; masid[vic] = asid;
            mppn[vic] = ppn; msz[vic] = sz; mpr[vic] = pr;
            mbyte = byte_touch(mbyte, vic);
        end
        chk(req, lru_state, mbyte[7:2], "lru_state");
    endtask

    initial begin
        forever begin
            @(posedge clk);
            cyc++;
            if (cyc > 100000) begin
                errors++;
                checks++;
                $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
                $display("Simulation finished: %0d checks, %0d errors", checks, errors);
                $finish;
            end
        end
    end

    initial begin
        logic [31:0] pool[5];
        void'($urandom(32'd20240611));
        for (int w = 0; w < 4; w++) begin
            mv[w] = 0; msh[w] = 0; mvpn[w] = '0; masid[w] = '0; mppn[w] = '0; msz[w] = '0; mpr[w] = '0;
        end
        mbyte = 8'h00;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);

        // R1 reset state
        chk("R1", rsp_valid, 0, "rsp_valid");
        chk("R1", fill_done, 0, "fill_done");
        chk("R1", fill_err, 0, "fill_err");
        chk("R1", lru_state, 0, "lru_state");
        lookup("R1", 32'h0040_0000, 8'd5, 1);

        // R6 R7 full replacement cycle: ways 3,2,1,0
        fill("R6", 32'h0040_0000, 8'd5, 19'h0_1111, 2'd0, 0, 2'd2, 1);
        fill("R6", 32'h0100_3000, 8'd5, 19'h0_2223, 2'd1, 1, 2'd3, 1);
        fill("R6", 32'h0200_0000, 8'd9, 19'h0_3340, 2'd2, 0, 2'd1, 1);
        fill("R7", 32'h1230_0000, 8'd5, 19'h5_A800, 2'd3, 0, 2'd0, 1);

        // R2 identifier rules
        lookup("R2", 32'h0200_1234, 8'd5, 1);   // mismatch
        lookup("R2", 32'h0200_1234, 8'd5, 0);   // check off
        lookup("R2", 32'h0100_3ABC, 8'd77, 1);  // shared
        lookup("R2", 32'h0040_0010, 8'd9, 1);   // mismatch
        // R3 page sizes, last byte and one past
        lookup("R3", 32'h0040_03FF, 8'd5, 1);
        lookup("R3", 32'h0040_0400, 8'd5, 1);
        lookup("R3", 32'h0100_3FFF, 8'd5, 1);
        lookup("R3", 32'h0100_4000, 8'd5, 1);
        lookup("R3", 32'h0200_FFFF, 8'd9, 1);
        lookup("R3", 32'h0201_0000, 8'd9, 1);
        lookup("R3", 32'h123F_FFFF, 8'd5, 1);
        lookup("R3", 32'h1240_0000, 8'd5, 1);
        // R5 hits on each way move the field
        lookup("R5", 32'h0040_0004, 8'd5, 1);
        lookup("R5", 32'h0200_0008, 8'd9, 1);
        lookup("R5", 32'h1234_5678, 8'd5, 1);
        lookup("R5", 32'h0100_3004, 8'd1, 1);

        // R4 overlapping page gives multiple hit, field unchanged
        fill("R4", 32'h1238_0000, 8'd5, 19'h0_0777, 2'd0, 0, 2'd2, 1);
        lookup("R4", 32'h1238_0100, 8'd5, 1);

        // R8 refused fill after loading 0x02
        lru_wr_data = 6'h02; lru_wr_en = 1;
        step();
        mbyte = {6'h02, 2'b00};
        chk("R9", lru_state, 6'h02, "lru_state after load");
        fill("R8", 32'h0700_0000, 8'd5, 19'h0_0999, 2'd1, 0, 2'd2, 1);
        lookup("R8", 32'h0700_0000, 8'd5, 1);    // must still miss

        // R9 load beats fill and lookup
        lru_wr_data = 6'h38; lru_wr_en = 1; fill_en = 1; fill_vpn = 22'h1C000; fill_valid = 1;
        lk_valid = 1; lk_vaddr = 32'h0040_0000;
        step();
        mbyte = 8'hE0;
        chk("R9", fill_done, 0, "fill_done");
        chk("R9", rsp_valid, 0, "rsp_valid");
        chk("R9", lru_state, 6'h38, "lru_state");
        lookup("R9", 32'h0700_0000, 8'd5, 1);

        // R10 fill beats lookup: only the fill's field change appears
        lk_valid = 1; lk_vaddr = 32'h0100_3000; lk_asid = 8'd5; lk_use_asid = 1;
        fill("R10", 32'h0900_0000, 8'd3, 19'h0_4321, 2'd1, 0, 2'd3, 1);
        chk("R10", rsp_valid, 0, "rsp_valid");
        step();
        chk("R11", rsp_valid, 0, "rsp_valid idle");

        // random mix
        pool[0] = 32'h0040_0000; pool[1] = 32'h0100_3000; pool[2] = 32'h0200_0000;
        pool[3] = 32'h1230_0000; pool[4] = 32'h1238_0000;
        for (int it = 0; it < 600; it++) begin
            if ($urandom_range(0, 3) == 0) begin
                logic [31:0] b = ($urandom_range(0, 5) == 5) ? $urandom : pool[$urandom_range(0, 4)];
                fill("R7", b, ($urandom_range(0, 1) != 0) ? 8'd5 : 8'($urandom),
                     19'($urandom), 2'($urandom), ($urandom_range(0, 3) == 0), 2'($urandom),
                     ($urandom_range(0, 7) != 0));
            end else begin
                int k = $urandom_range(0, 4);
                logic [31:0] va;
                if (k == 4) va = $urandom;
                else va = ({mvpn[k], 10'b0} & ~(pg_bytes(msz[k]) - 1)) +
                          ($urandom % (pg_bytes(msz[k]) + 32'd16));
                lookup("R2", va, ($urandom_range(0, 2) != 0) ? 8'd5 : 8'($urandom),
                       ($urandom_range(0, 3) != 0));
            end
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule